// File: doc/BRIEF.md
# Memory-Mapped ATA Register Bridge

This block sits between a simple memory-mapped host port and the register file of a parallel ATA device. A host access carries an address, a size qualifier (byte, halfword or word), a direction and write data. The bridge takes the register index from the address window. It decides whether the access reaches a task-file register, the device control/alternate status register, or the data register. It then issues a single-cycle strobe on the matching downstream select line, along with the register number and formatted write data.

Only the data register carries transfers wider than a byte, and its bytes are reordered on the way in and on the way out. Any access the map does not cover completes normally. A read of such an access returns all ones for its width, and a write is dropped without touching the device. Every request is answered one cycle later with a ready pulse, so the host can issue a new request on every cycle.

Top module: `ide_mmio_bridge`

## Requirements
- R1: The register index is address bits [11:4]. Address bits [3:0] and all bits above bit 11 have no effect on routing, so an address plus 0x1000, or plus 0x8, reaches the same register.
- R2: A byte access (h_size = 0) at index 1..7 pulses d_tf_stb with d_reg equal to the index. Byte write data travels unswapped in bits [7:0], and the device's bits [7:0] return zero-extended on h_rdata.
- R3: A byte access at index 8 or at index 22 pulses d_ctl_stb. A write sends the byte to the device control register, and a read returns the device's alternate status byte.
- R4: A byte read at any other index, index 0 included, returns 0x000000FF and pulses no strobe. A byte write there pulses no strobe.
- R5: A halfword (h_size = 1) or word (h_size = 2) access at index 0 pulses d_dat_stb. d_wide is 1 for a word and 0 for a halfword.
- R6: A halfword or word access at any index other than 0 pulses no strobe. The read returns 0x0000FFFF for a halfword and 0xFFFFFFFF for a word.
- R7: A halfword data transfer swaps its two bytes in both directions. Host bits [15:8] travel to device bits [7:0] and back, and the upper 16 bits are zero.
- R8: A word data transfer reverses all four bytes in both directions, so host byte 0 meets device byte 3.
- R9: Every request raises h_ready on the next cycle only. A mapped access raises exactly one strobe for exactly one cycle, and d_we follows the request direction. Back-to-back requests on consecutive cycles are all served.
- R10: While rst is high, h_ready and all strobes are low. d_rst is high for exactly the first cycle after rst is sampled high.
- R11: The reserved size code (h_size = 3) never pulses a strobe, and its read returns 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| h_req | input | 1 | Host request, one cycle per access |
| h_we | input | 1 | 1 = write, 0 = read |
| h_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| h_addr | input | ADDR_W | Host byte address |
| h_wdata | input | 32 | Host write data, little lanes from bit 0 |
| h_ready | output | 1 | Completion pulse, one cycle after h_req |
| h_rdata | output | 32 | Read data, valid with h_ready |
| d_tf_stb | output | 1 | Task-file register strobe |
| d_ctl_stb | output | 1 | Control/alternate status strobe |
| d_dat_stb | output | 1 | Data register strobe |
| d_we | output | 1 | Downstream write qualifier |
| d_reg | output | 3 | Task-file register number |
| d_wide | output | 1 | Data access is a word (1) or halfword (0) |
| d_wdata | output | 32 | Formatted downstream write data |
| d_rdata | input | 32 | Device read data, sampled during a strobe |
| d_rst | output | 1 | One-cycle downstream reset pulse |

## Verification
The bound checker watches the timing on every cycle. It checks that at most one strobe is active at a time and that every strobe coincides with a ready that answers a request from the previous cycle. It also checks that a data strobe only follows an index-0 wide access, that unmapped byte reads return 0xFF, and that reset holds everything quiet with d_rst as a single-cycle pulse. Only the directed scenarios can show the data itself. They check byte reordering in each direction, the values routed from the device model, aliasing across address bits outside [11:4], and the choice of destination for every size and index class.

// File: rtl/ide_mmio_pkg.sv
package ide_mmio_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

   typedef enum logic [1:0] {
      RT_NONE = 2'd0,
      RT_TASK = 2'd1,
      RT_CTRL = 2'd2,
      RT_DATA = 2'd3
   } route_e;

   localparam int unsigned BUS_W = 32;

   function automatic logic [15:0] swap_half(input logic [15:0] v);
      return {v[7:0], v[15:8]};
   endfunction

   function automatic logic [31:0] swap_word(input logic [31:0] v);
      return {v[7:0], v[15:8], v[23:16], v[31:24]};
   endfunction

   function automatic logic [31:0] ones_for(input acc_size_e sz);
      case (sz)
         SZ_BYTE: return 32'h0000_00FF;
         SZ_HALF: return 32'h0000_FFFF;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

endpackage

// File: rtl/ide_reg_decode.sv
module ide_reg_decode
   import ide_mmio_pkg::*;
#(
   parameter int IDX_W      = 8,
   parameter int TF_FIRST   = 1,
   parameter int TF_LAST    = 7,
   parameter int CTRL_IDX_A = 8,
   parameter int CTRL_IDX_B = 22,
   parameter int DATA_IDX   = 0
) (
   input  logic [IDX_W-1:0] idx,
   input  acc_size_e        size,
   output route_e           route,
   output logic [2:0]       tf_reg
);

   localparam logic [IDX_W-1:0] CA = IDX_W'(CTRL_IDX_A);
   localparam logic [IDX_W-1:0] CB = IDX_W'(CTRL_IDX_B);
   localparam logic [IDX_W-1:0] DI = IDX_W'(DATA_IDX);
   localparam logic [IDX_W-1:0] TF_LO = IDX_W'(TF_FIRST);
   localparam logic [IDX_W-1:0] TF_HI = IDX_W'(TF_LAST);

   logic in_tf;
   logic is_ctl;
   logic is_dat;

   always_comb begin
      in_tf  = (idx >= TF_LO) && (idx <= TF_HI);
      is_ctl = (idx == CA) || (idx == CB);
      is_dat = (idx == DI);
   end

   always_comb begin
      route  = RT_NONE;
      tf_reg = 3'd0;
      case (size)
         SZ_BYTE: begin
            if (in_tf) begin
               route  = RT_TASK;
               tf_reg = idx[2:0];
            end else if (is_ctl) begin
               route = RT_CTRL;
            end
         end
         SZ_HALF, SZ_WORD: begin
            if (is_dat) route = RT_DATA;
         end
         default: route = RT_NONE;
      endcase
   end

endmodule

// File: rtl/ide_data_lane.sv
module ide_data_lane
   import ide_mmio_pkg::*;
#(
   parameter bit SWAP_EN = 1'b1
) (
   input  acc_size_e   size,
   input  logic [31:0] din,
   output logic [31:0] dout
);

   logic [15:0] half_fmt;
   logic [31:0] word_fmt;

   generate
      if (SWAP_EN) begin : g_swap
         always_comb begin
            half_fmt = swap_half(din[15:0]);
            word_fmt = swap_word(din);
         end
      end else begin : g_pass
         always_comb begin
            half_fmt = din[15:0];
            word_fmt = din;
         end
      end
   endgenerate

   always_comb begin
      case (size)
         SZ_BYTE: dout = {24'h0, din[7:0]};
         SZ_HALF: dout = {16'h0, half_fmt};
         SZ_WORD: dout = word_fmt;
         default: dout = 32'h0;
      endcase
   end

endmodule

// File: rtl/ide_mmio_bridge.sv
module ide_mmio_bridge
   import ide_mmio_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int WIN_BITS    = 12,
   parameter int STRIDE_LOG2 = 4,
   parameter int TF_FIRST    = 1,
   parameter int TF_LAST     = 7,
   parameter int CTRL_IDX_A  = 8,
   parameter int CTRL_IDX_B  = 22,
   parameter int DATA_IDX    = 0,
   parameter bit SWAP_EN     = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              h_req,
   input  logic              h_we,
   input  logic [1:0]        h_size,
   input  logic [ADDR_W-1:0] h_addr,
   input  logic [31:0]       h_wdata,
   output logic              h_ready,
   output logic [31:0]       h_rdata,
   output logic              d_tf_stb,
   output logic              d_ctl_stb,
   output logic              d_dat_stb,
   output logic              d_we,
   output logic [2:0]        d_reg,
   output logic              d_wide,
   output logic [31:0]       d_wdata,
   input  logic [31:0]       d_rdata,
   output bit                d_rst
);

   localparam int IDX_W = WIN_BITS - STRIDE_LOG2;

   generate
      if (ADDR_W <= WIN_BITS) begin : g_bad_addr
         $error("ADDR_W must exceed WIN_BITS");
      end
      if (IDX_W < 5) begin : g_bad_idx
         $error("index field too narrow for the control aliases");
      end
      if (TF_LAST > 7 || TF_FIRST < 1 || TF_FIRST > TF_LAST) begin : g_bad_tf
         $error("task-file range must lie inside 1..7");
      end
      if (CTRL_IDX_A >= (1 << IDX_W) || CTRL_IDX_B >= (1 << IDX_W)) begin : g_bad_ctl
         $error("control index outside the window");
      end
   endgenerate

   // address fields
   logic [IDX_W-1:0] idx;
   logic             unused_addr;

   always_comb begin
      idx         = h_addr[WIN_BITS-1:STRIDE_LOG2];
      unused_addr = ^{h_addr[ADDR_W-1:WIN_BITS], h_addr[STRIDE_LOG2-1:0]};
   end

   // decode
   acc_size_e  size_n;
   route_e     route_n;
   logic [2:0] reg_n;

   assign size_n = acc_size_e'(h_size);

   ide_reg_decode #(
      .IDX_W     (IDX_W),
      .TF_FIRST  (TF_FIRST),
      .TF_LAST   (TF_LAST),
      .CTRL_IDX_A(CTRL_IDX_A),
      .CTRL_IDX_B(CTRL_IDX_B),
      .DATA_IDX  (DATA_IDX)
   ) dec_i (
      .idx   (idx),
      .size  (size_n),
      .route (route_n),
      .tf_reg(reg_n)
   );

   // write-path formatting
   logic [31:0] wfmt;

   ide_data_lane #(.SWAP_EN(SWAP_EN)) wlane_i (
      .size(size_n),
      .din (h_wdata),
      .dout(wfmt)
   );

   // request stage
   logic        req_q;
   logic        we_q;
   acc_size_e   size_q;
   route_e      route_q;
   logic [2:0]  reg_q;
   logic [31:0] wdata_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         req_q   <= 1'b0;
         we_q    <= 1'b0;
         size_q  <= SZ_BYTE;
         route_q <= RT_NONE;
         reg_q   <= 3'd0;
         wdata_q <= 32'h0;
      end else begin
         req_q <= h_req;
         if (h_req) begin
            we_q    <= h_we;
            size_q  <= size_n;
            route_q <= route_n;
            reg_q   <= reg_n;
            wdata_q <= (route_n != RT_NONE && h_we) ? wfmt : 32'h0;
         end
      end
   end

   // downstream reset pulse
   bit rst_seen_q;

   always_ff @(posedge clk) begin
      rst_seen_q <= rst;
      d_rst      <= rst && !rst_seen_q;
   end

   // downstream outputs
   logic live;

   always_comb begin
      live      = req_q && (route_q != RT_NONE);
      d_tf_stb  = req_q && (route_q == RT_TASK);
      d_ctl_stb = req_q && (route_q == RT_CTRL);
      d_dat_stb = req_q && (route_q == RT_DATA);
      d_we      = live && we_q;
      d_reg     = (route_q == RT_TASK) ? reg_q : 3'd0;
      d_wide    = (route_q == RT_DATA) && (size_q == SZ_WORD);
      d_wdata   = wdata_q;
   end

   // read-path formatting
   logic [31:0] rfmt;

   ide_data_lane #(.SWAP_EN(SWAP_EN)) rlane_i (
      .size(size_q),
      .din (d_rdata),
      .dout(rfmt)
   );

   always_comb begin
      h_ready = req_q;
      if (!req_q || we_q)
         h_rdata = 32'h0;
      else if (route_q == RT_NONE)
         h_rdata = ones_for(size_q);
      else
         h_rdata = rfmt;
   end

endmodule

module ide_mmio_bridge_chk
   import ide_mmio_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              h_req,
   input logic              h_we,
   input logic [1:0]        h_size,
   input logic [ADDR_W-1:0] h_addr,
   input logic              h_ready,
   input logic [31:0]       h_rdata,
   input logic              d_tf_stb,
   input logic              d_ctl_stb,
   input logic              d_dat_stb,
   input logic              d_rst
);

   // R9
   strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0({d_tf_stb, d_ctl_stb, d_dat_stb}));

   // R9
   ready_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
      h_req |=> h_ready);

   // R9
   no_spurious_ready_chk: assert property (@(posedge clk) disable iff (rst)
      !h_req |=> !h_ready);

   // R9
   strobe_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
      (d_tf_stb || d_ctl_stb || d_dat_stb) |-> h_ready);

   // R5
   data_only_idx0_chk: assert property (@(posedge clk) disable iff (rst)
      d_dat_stb |-> ($past(h_addr[11:4]) == 8'd0 && $past(h_size) != 2'd0));

   // R4
   unmapped_byte_ff_chk: assert property (@(posedge clk) disable iff (rst)
      (h_ready && $past(h_size) == 2'd0 && !$past(h_we)
       && !d_tf_stb && !d_ctl_stb) |-> (h_rdata == 32'h0000_00FF));

   // R11
   rsvd_size_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (h_req && h_size == 2'd3) |=> !(d_tf_stb || d_ctl_stb || d_dat_stb));

   // R10
   reset_quiet_chk: assert property (@(posedge clk)
      rst |=> !(h_ready || d_tf_stb || d_ctl_stb || d_dat_stb));

   // R10
   dev_reset_pulse_chk: assert property (@(posedge clk)
      d_rst |=> !d_rst);

endmodule

bind ide_mmio_bridge ide_mmio_bridge_chk #(.ADDR_W(ADDR_W)) chk_i (
   .clk      (clk),
   .rst      (rst),
   .h_req    (h_req),
   .h_we     (h_we),
   .h_size   (h_size),
   .h_addr   (h_addr),
   .h_ready  (h_ready),
   .h_rdata  (h_rdata),
   .d_tf_stb (d_tf_stb),
   .d_ctl_stb(d_ctl_stb),
   .d_dat_stb(d_dat_stb),
   .d_rst    (d_rst)
);

// File: tb/ide_mmio_bridge_tb.sv
module ide_mmio_bridge_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        h_req = 1'b0;
   logic        h_we = 1'b0;
   logic [1:0]  h_size = 2'd0;
   logic [15:0] h_addr = 16'h0;
   logic [31:0] h_wdata = 32'h0;
   logic        h_ready;
   logic [31:0] h_rdata;
   logic        d_tf_stb, d_ctl_stb, d_dat_stb, d_we, d_wide;
   logic [2:0]  d_reg;
   logic [31:0] d_wdata;
   logic [31:0] d_rdata;
   bit          d_rst;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   ide_mmio_bridge dut_i (
      .clk(clk), .rst(rst), .h_req(h_req), .h_we(h_we), .h_size(h_size),
      .h_addr(h_addr), .h_wdata(h_wdata), .h_ready(h_ready), .h_rdata(h_rdata),
      .d_tf_stb(d_tf_stb), .d_ctl_stb(d_ctl_stb), .d_dat_stb(d_dat_stb),
      .d_we(d_we), .d_reg(d_reg), .d_wide(d_wide), .d_wdata(d_wdata),
      .d_rdata(d_rdata), .d_rst(d_rst)
   );

   // device model
   always_comb begin
      if (d_tf_stb)       d_rdata = {24'h0, 5'b10100, d_reg};
      else if (d_ctl_stb) d_rdata = 32'h0000_005C;
      else if (d_dat_stb) d_rdata = 32'h1122_3344;
      else                d_rdata = 32'hDEAD_BEEF;
   end

   // captured results
   logic [31:0] c_rdata, c_wdata;
   logic [2:0]  c_stb, c_reg, p_stb;
   logic        c_ready, c_we, c_wide, p_ready;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic issue(input logic we, input logic [1:0] sz, input logic [15:0] a,
                        input logic [31:0] wd);
      @(negedge clk);
      h_req = 1'b1; h_we = we; h_size = sz; h_addr = a; h_wdata = wd;
      @(negedge clk);
      h_req = 1'b0;
      c_ready = h_ready; c_rdata = h_rdata; c_wdata = d_wdata;
      c_stb = {d_tf_stb, d_ctl_stb, d_dat_stb};
      c_reg = d_reg; c_we = d_we; c_wide = d_wide;
      @(negedge clk);
      p_stb = {d_tf_stb, d_ctl_stb, d_dat_stb}; p_ready = h_ready;
   endtask

   task automatic t_reset_state();
      check("R10 ready low", {31'h0, h_ready}, 32'h0);
      check("R10 strobes low", {29'h0, d_tf_stb, d_ctl_stb, d_dat_stb}, 32'h0);
      check("R10 d_rst over", {31'h0, d_rst}, 32'h0);
   endtask

   task automatic t_task_file();
      issue(1'b0, 2'd0, 16'h0030, 32'h0);
      check("R2 tf read strobe", {29'h0, c_stb}, 32'h4);
      check("R2 tf read reg", {29'h0, c_reg}, 32'h3);
      check("R2 tf read data", c_rdata, 32'h0000_00A3);
      check("R9 ready", {31'h0, c_ready}, 32'h1);
      check("R9 one cycle", {28'h0, p_ready, p_stb}, 32'h0);
      issue(1'b1, 2'd0, 16'h0070, 32'h1234_565A);
      check("R2 tf write strobe", {29'h0, c_stb}, 32'h4);
      check("R2 tf write reg/we", {28'h0, c_we, c_reg}, 32'hF);
      check("R2 tf write data", c_wdata, 32'h0000_005A);
   endtask

   task automatic t_control();
      issue(1'b1, 2'd0, 16'h0080, 32'h0000_0006);
      check("R3 ctl write idx8", {28'h0, c_we, c_stb}, 32'hA);
      check("R3 ctl write data", c_wdata, 32'h0000_0006);
      issue(1'b1, 2'd0, 16'h0160, 32'h0000_0002);
      check("R3 ctl write idx22", {28'h0, c_we, c_stb}, 32'hA);
      issue(1'b0, 2'd0, 16'h0160, 32'h0);
      check("R3 alt status idx22", c_rdata, 32'h0000_005C);
      issue(1'b0, 2'd0, 16'h0080, 32'h0);
      check("R3 alt status idx8", c_rdata, 32'h0000_005C);
      check("R3 read not write", {31'h0, c_we}, 32'h0);
   endtask

   task automatic t_unmapped_byte();
      issue(1'b0, 2'd0, 16'h0090, 32'h0);
      check("R4 byte read idx9", c_rdata, 32'h0000_00FF);
      check("R4 no strobe idx9", {29'h0, c_stb}, 32'h0);
      issue(1'b1, 2'd0, 16'h01E0, 32'h0000_0011);
      check("R4 byte write idx30 dropped", {28'h0, c_we, c_stb}, 32'h0);
      issue(1'b0, 2'd0, 16'h0000, 32'h0);
      check("R4 byte read idx0", c_rdata, 32'h0000_00FF);
      check("R4 byte idx0 no strobe", {29'h0, c_stb}, 32'h0);
   endtask

   task automatic t_alias();
      issue(1'b0, 2'd0, 16'h1030, 32'h0);
      check("R1 alias above window", {c_stb, c_reg}, 6'h23);
      issue(1'b0, 2'd0, 16'h003B, 32'h0);
      check("R1 low nibble ignored", c_rdata, 32'h0000_00A3);
      issue(1'b0, 2'd1, 16'hF00C, 32'h0);
      check("R1 data alias", {29'h0, c_stb}, 32'h1);
   endtask

   task automatic t_data();
      issue(1'b0, 2'd1, 16'h0000, 32'h0);
      check("R5 half strobe/wide", {28'h0, c_wide, c_stb}, 32'h1);
      check("R7 half read swap", c_rdata, 32'h0000_4433);
      issue(1'b1, 2'd1, 16'h0000, 32'hAAAA_BEEF);
      check("R7 half write swap", c_wdata, 32'h0000_EFBE);
      issue(1'b0, 2'd2, 16'h0000, 32'h0);
      check("R5 word strobe/wide", {28'h0, c_wide, c_stb}, 32'h9);
      check("R8 word read reverse", c_rdata, 32'h4433_2211);
      issue(1'b1, 2'd2, 16'h0000, 32'h0102_0304);
      check("R8 word write reverse", c_wdata, 32'h0403_0201);
      check("R9 write we", {31'h0, c_we}, 32'h1);
   endtask

   task automatic t_unmapped_wide();
      issue(1'b0, 2'd1, 16'h0010, 32'h0);
      check("R6 half read idx1", c_rdata, 32'h0000_FFFF);
      check("R6 half no strobe", {29'h0, c_stb}, 32'h0);
      issue(1'b0, 2'd2, 16'h0020, 32'h0);
      check("R6 word read idx2", c_rdata, 32'hFFFF_FFFF);
      issue(1'b1, 2'd2, 16'h0050, 32'h1234_5678);
      check("R6 word write dropped", {28'h0, c_we, c_stb}, 32'h0);
      issue(1'b0, 2'd2, 16'h0080, 32'h0);
      check("R6 word at ctl idx", {29'h0, c_stb}, 32'h0);
   endtask

   task automatic t_reserved();
      issue(1'b0, 2'd3, 16'h0000, 32'h0);
      check("R11 rsvd read", c_rdata, 32'hFFFF_FFFF);
      check("R11 rsvd no strobe", {29'h0, c_stb}, 32'h0);
      issue(1'b1, 2'd3, 16'h0030, 32'h0);
      check("R11 rsvd write", {28'h0, c_we, c_stb}, 32'h0);
   endtask

   task automatic t_back_to_back();
      @(negedge clk);
      h_req = 1'b1; h_we = 1'b0; h_size = 2'd0; h_addr = 16'h0050;
      @(negedge clk);
      check("R9 b2b first tf", {d_tf_stb, d_ctl_stb, d_dat_stb, d_reg}, 6'h25);
      check("R9 b2b first data", h_rdata, 32'h0000_00A5);
      h_we = 1'b1; h_addr = 16'h0080; h_wdata = 32'h4;
      @(negedge clk);
      check("R9 b2b second ctl", {h_ready, d_we, d_tf_stb, d_ctl_stb, d_dat_stb}, 5'h1A);
      h_req = 1'b0;
      @(negedge clk);
      check("R9 b2b idle", {29'h0, h_ready, d_ctl_stb, d_tf_stb}, 32'h0);
   endtask

   task automatic t_reset_mid();
      @(negedge clk);
      h_req = 1'b1; h_we = 1'b0; h_size = 2'd0; h_addr = 16'h0030; rst = 1'b1;
      @(negedge clk);
      check("R10 reset blocks access", {28'h0, h_ready, d_tf_stb, d_ctl_stb, d_dat_stb}, 32'h0);
      check("R10 d_rst pulse", {31'h0, d_rst}, 32'h1);
      @(negedge clk);
      check("R10 d_rst one cycle", {31'h0, d_rst}, 32'h0);
      h_req = 1'b0; rst = 1'b0;
      @(negedge clk);
      check("R10 quiet after", {30'h0, h_ready, d_rst}, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset_state();
      t_task_file();
      t_control();
      t_unmapped_byte();
      t_alias();
      t_data();
      t_unmapped_wide();
      t_reserved();
      t_back_to_back();
      t_reset_mid();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

endmodule